// File: doc/BRIEF.md
# DRAM Rank Idle Power-Down Controller

This block sits beside the command scheduler of one DRAM channel. It tracks how long each rank has gone without work, and it drops that rank's clock-enable (CKE) once the idle time reaches a programmed threshold. The rank stays in power-down until work returns and a minimum CKE-low time has passed. When the rank wakes, CKE goes high again and a one-cycle exit request tells the scheduler that the rank is back.

A 13-bit configuration word sets the behaviour. Bits [7:0] hold the idle threshold, counted in clock cycles. Bits [11:8] hold the power-down flavour code, and bit 12 selects between two decision styles: each rank on its own, or the whole channel as one. The controller reports the flavour that each rank is in, so the downstream sequencer can choose the matching entry and exit procedure. A configuration write that arrives while any rank is powered down is kept aside and takes effect once every rank is up again.

Top module: `pdwn_ctrl`

## Requirements
- R1: After reset every CKE is high, every pd_kind field is 0, exit_req is 0, and the active configuration is zero (power-down off).
- R2: In per-rank mode (bit 12 = 0), with an enabled flavour and a threshold T > 0 in bits [7:0], a rank drops CKE at the end of its (T+1)-th consecutive cycle without activity. Other ranks are unaffected.
- R3: A command strobe or a pending request on a rank counts as activity and restarts that rank's idle count from zero.
- R4: A threshold of 0 means power-down is never entered, however long the ranks stay idle.
- R5: Mode code 0h and the reserved codes (everything except 1h, 2h, 3h, 6h, 7h in bits [11:8]) never cause entry, and CKE stays high.
- R6: While a rank's CKE is low, its 3-bit pd_kind field (bits [3r+2:3r]) gives the flavour. Mode 1h gives 1, 2h gives 2, 3h gives 3, 6h gives 4 and 7h gives 5. While CKE is high the field is 0.
- R7: In global mode (bit 12 = 1), all ranks drop CKE in the same cycle, and only once every rank meets the idle condition. Activity on any rank then wakes all of them in the same cycle.
- R8: Once CKE falls it stays low for at least 4 cycles, even if activity arrives sooner.
- R9: CKE returns high at the first clock edge where the minimum low time is met and the rank has activity (in global mode, activity on any rank). exit_req for that rank is 1 for exactly that one cycle and is 0 at all other times.
- R10: A configuration write (cfg_wr) takes effect at the clock edge where it is sampled, provided every rank is up and none is entering power-down at that edge. Otherwise it is held, and it is applied at the first edge where that condition holds. A newer write replaces a held one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_word | input | 13 | Configuration: [7:0] threshold, [11:8] mode, [12] global |
| cmd_issued | input | NUM_RANKS | Per-rank command issued this cycle |
| req_pending | input | NUM_RANKS | Per-rank request waiting in the scheduler |
| cke | output | NUM_RANKS | Per-rank clock enable |
| pd_kind | output | 3*NUM_RANKS | Per-rank power-down flavour, 0 when CKE is high |
| exit_req | output | NUM_RANKS | One-cycle pulse when a rank leaves power-down |

## Verification
All outputs come from registers, so every result is due one edge after the input that causes it. A rank falls T+1 edges after its last activity. A rank rises 4 edges after it fell, at the earliest. A configuration write shows its effect on the edge after the strobe, or later if it is held. The bench drives inputs and samples outputs on the falling edge, half a cycle away from the edge where they change. A reference model steps on each rising edge from the same inputs and is compared with the outputs at every falling edge. The directed checks wait an exact count of falling edges that is derived from these latencies.

// File: rtl/pdwn_pkg.sv
package pdwn_pkg;

  localparam int CFG_THR_W  = 8;
  localparam int CFG_MODE_W = 4;

  typedef struct packed {
    logic                  glob;
    logic [CFG_MODE_W-1:0] mode;
    logic [CFG_THR_W-1:0]  thr;
  } pdwn_cfg_t;

  localparam int CFG_W = $bits(pdwn_cfg_t);

  typedef enum logic [2:0] {
    KIND_NONE      = 3'd0,
    KIND_ACTIVE    = 3'd1,
    KIND_PRECHG    = 3'd2,
    KIND_ACT_PRE   = 3'd3,
    KIND_SLOW      = 3'd4,
    KIND_ACT_SLOW  = 3'd5
  } pd_kind_e;

  // Mode code to flavour; unlisted codes are reserved and disable entry.
  function automatic pd_kind_e decode_mode(input logic [CFG_MODE_W-1:0] m);
    case (m)
      4'h1:    return KIND_ACTIVE;
      4'h2:    return KIND_PRECHG;
      4'h3:    return KIND_ACT_PRE;
      4'h6:    return KIND_SLOW;
      4'h7:    return KIND_ACT_SLOW;
      default: return KIND_NONE;
    endcase
  endfunction

  // Zero threshold means the rank never qualifies.
  function automatic logic idle_reached(input logic [CFG_THR_W-1:0] cnt,
                                        input logic [CFG_THR_W-1:0] thr);
    return (thr != '0) && (cnt >= thr);
  endfunction

endpackage

// File: rtl/pdwn_cfg_hold.sv
module pdwn_cfg_hold
  import pdwn_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  pdwn_cfg_t wdata,
  input  logic      apply_ok,
  output pdwn_cfg_t cfg_q
);

  pdwn_cfg_t held_q;
  logic      held_vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      held_q     <= '0;
      held_vld_q <= 1'b0;
    end else if (wr) begin
      if (apply_ok) begin
        cfg_q      <= wdata;
        held_vld_q <= 1'b0;
      end else begin
        held_q     <= wdata;
        held_vld_q <= 1'b1;
      end
    end else if (held_vld_q && apply_ok) begin
      cfg_q      <= held_q;
      held_vld_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pdwn_idle_cnt.sv
module pdwn_idle_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         busy,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (busy)           cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pdwn_rank_fsm.sv
module pdwn_rank_fsm #(
  parameter int MIN_LOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter,
  input  logic wake,
  output logic cke,
  output logic exit_req,
  output logic min_met
);

  localparam int LCW = $clog2(MIN_LOW + 1);
  localparam logic [LCW-1:0] LOW_TGT = LCW'(MIN_LOW);

  logic [LCW-1:0] low_cnt;

  assign min_met = (low_cnt >= LOW_TGT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke      <= 1'b1;
      exit_req <= 1'b0;
      low_cnt  <= '0;
    end else if (cke) begin
      exit_req <= 1'b0;
      if (enter) begin
        cke     <= 1'b0;
        low_cnt <= LCW'(1);
      end
    end else if (min_met && wake) begin
      cke      <= 1'b1;
      exit_req <= 1'b1;
      low_cnt  <= '0;
    end else begin
      exit_req <= 1'b0;
      if (!min_met) low_cnt <= low_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pdwn_ctrl.sv
module pdwn_ctrl
  import pdwn_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int MIN_LOW   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_wr,
  input  logic [CFG_W-1:0]       cfg_word,
  input  logic [NUM_RANKS-1:0]   cmd_issued,
  input  logic [NUM_RANKS-1:0]   req_pending,
  output logic [NUM_RANKS-1:0]   cke,
  output logic [3*NUM_RANKS-1:0] pd_kind,
  output logic [NUM_RANKS-1:0]   exit_req
);

  pdwn_cfg_t cfg_act;
  pd_kind_e  kind;
  logic      pd_en;
  logic      cfg_ok;
  logic      all_ready;
  logic      any_act;

  logic [NUM_RANKS-1:0] act;
  logic [NUM_RANKS-1:0] ready;
  logic [NUM_RANKS-1:0] enter;
  logic [NUM_RANKS-1:0] wake;
  logic [NUM_RANKS-1:0] min_met;

  assign act       = cmd_issued | req_pending;
  assign kind      = decode_mode(cfg_act.mode);
  assign pd_en     = (kind != KIND_NONE);
  assign all_ready = &ready;
  assign any_act   = |act;
  assign cfg_ok    = (&cke) && !(|enter);

  pdwn_cfg_hold u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (cfg_wr),
    .wdata    (pdwn_cfg_t'(cfg_word)),
    .apply_ok (cfg_ok),
    .cfg_q    (cfg_act)
  );

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic [CFG_THR_W-1:0] idle_cnt;

    pdwn_idle_cnt #(.W(CFG_THR_W)) u_idle (
      .clk   (clk),
      .rst_n (rst_n),
      .busy  (act[r]),
      .cnt   (idle_cnt)
    );

    assign ready[r] = pd_en && !act[r] && idle_reached(idle_cnt, cfg_act.thr);
    assign enter[r] = cke[r] && (cfg_act.glob ? all_ready : ready[r]);
    assign wake[r]  = cfg_act.glob ? any_act : act[r];

    pdwn_rank_fsm #(.MIN_LOW(MIN_LOW)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .enter    (enter[r]),
      .wake     (wake[r]),
      .cke      (cke[r]),
      .exit_req (exit_req[r]),
      .min_met  (min_met[r])
    );

    assign pd_kind[3*r +: 3] = cke[r] ? KIND_NONE : kind;
  end

endmodule

// File: rtl/pdwn_chk.sv
module pdwn_chk #(
  parameter int N       = 4,
  parameter int MIN_LOW = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] cke,
  input logic [N-1:0] exit_req,
  input logic [N-1:0] min_met,
  input logic         pd_en,
  input logic         glob,
  input logic [7:0]   thr,
  input logic [12:0]  cfg_act
);

  for (genvar r = 0; r < N; r++) begin : g_p
    p_min_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke[r]) |-> $past(min_met[r]))
      else $error("min CKE-low violated rank %0d", r);

    p_exit_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke[r]) |-> exit_req[r])
      else $error("rise without exit_req rank %0d", r);

    p_rise_has_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      exit_req[r] |-> $rose(cke[r]))
      else $error("stray exit_req rank %0d", r);

    p_no_entry_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke[r]) |-> $past(pd_en))
      else $error("entry with disabled mode rank %0d", r);

    p_thr_zero_never_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke[r]) |-> $past(thr != 8'd0))
      else $error("entry with zero threshold rank %0d", r);
  end

  p_global_lockstep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    glob |-> ((cke == '0) || (&cke)))
    else $error("ranks out of step in global mode");

  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(&cke) |=> $stable(cfg_act))
    else $error("configuration changed during power-down");

endmodule

bind pdwn_ctrl pdwn_chk #(.N(NUM_RANKS), .MIN_LOW(MIN_LOW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cke      (cke),
  .exit_req (exit_req),
  .min_met  (min_met),
  .pd_en    (pd_en),
  .glob     (cfg_act.glob),
  .thr      (cfg_act.thr),
  .cfg_act  (cfg_act)
);

// File: tb/pdwn_ctrl_test.sv
module pdwn_ctrl_test;
  localparam int N    = 4;
  localparam int MINL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [12:0]   cfg_word = '0;
  logic [N-1:0]  cmd_issued = '0;
  logic [N-1:0]  req_pending = '1;
  logic [N-1:0]  cke;
  logic [3*N-1:0] pd_kind;
  logic [N-1:0]  exit_req;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  pdwn_ctrl #(.NUM_RANKS(N), .MIN_LOW(MINL)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .cmd_issued(cmd_issued), .req_pending(req_pending),
    .cke(cke), .pd_kind(pd_kind), .exit_req(exit_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Flavour numbers as given in R6.
  function automatic int flavour(input logic [3:0] m);
    if (m == 4'h1) return 1;
    if (m == 4'h2) return 2;
    if (m == 4'h3) return 3;
    if (m == 4'h6) return 4;
    if (m == 4'h7) return 5;
    return 0;
  endfunction

  // Reference model
  int          m_idle[N];
  int          m_low[N];
  bit          m_up[N];
  bit          m_pulse[N];
  logic [12:0] m_cfg, m_held;
  bit          m_held_v;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++) begin
        m_idle[r] = 0; m_low[r] = 0; m_up[r] = 1; m_pulse[r] = 0;
      end
      m_cfg = '0; m_held = '0; m_held_v = 0;
    end else begin
      automatic int  thr   = int'(m_cfg[7:0]);
      automatic bit  glob  = m_cfg[12];
      automatic bit  on    = (flavour(m_cfg[11:8]) != 0) && (thr != 0);
      automatic bit  every = 1, some = 0, all_up = 1, going = 0;
      automatic bit  busy[N];
      automatic bit  go[N];
      for (int r = 0; r < N; r++) begin
        busy[r] = cmd_issued[r] || req_pending[r];
        if (busy[r]) some = 1;
        if (!(on && !busy[r] && m_idle[r] >= thr)) every = 0;
      end
      for (int r = 0; r < N; r++) begin
        go[r] = m_up[r] && (glob ? every : (on && !busy[r] && m_idle[r] >= thr));
        if (go[r]) going = 1;
        if (!m_up[r]) all_up = 0;
      end
      for (int r = 0; r < N; r++) begin
        m_pulse[r] = 0;
        if (m_up[r]) begin
          if (go[r]) begin m_up[r] = 0; m_low[r] = 0; end
        end else begin
          m_low[r]++;
          if (m_low[r] >= MINL && (glob ? some : busy[r])) begin
            m_up[r] = 1; m_pulse[r] = 1;
          end
        end
        m_idle[r] = busy[r] ? 0 : ((m_idle[r] < 255) ? m_idle[r] + 1 : 255);
      end
      if (cfg_wr) begin
        if (all_up && !going) begin m_cfg = cfg_word; m_held_v = 0; end
        else begin m_held = cfg_word; m_held_v = 1; end
      end else if (m_held_v && all_up && !going) begin
        m_cfg = m_held; m_held_v = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int r = 0; r < N; r++) begin
        automatic int ek = m_up[r] ? 0 : flavour(m_cfg[11:8]);
        chk(cke[r] === m_up[r], "R2 R7 R8 model cke", int'(cke[r]), int'(m_up[r]));
        chk(int'(pd_kind[3*r +: 3]) == ek, "R6 model kind", int'(pd_kind[3*r +: 3]), ek);
        chk(exit_req[r] === m_pulse[r], "R9 model exit_req", int'(exit_req[r]), int'(m_pulse[r]));
      end
    end
  end

  task automatic wr_cfg(input logic [12:0] w);
    cfg_word = w; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    chk(cke == 4'b1111, "R1 cke", int'(cke), 'hf);
    chk(pd_kind == '0, "R1 pd_kind", int'(pd_kind), 0);
    chk(exit_req == '0, "R1 exit_req", int'(exit_req), 0);

    // R2 per-rank entry, threshold 3, flavour 1h
    wr_cfg(13'h0103);
    req_pending = 4'b1110;
    wait_n(3);
    chk(cke == 4'b1111, "R2 before T+1", int'(cke), 'hf);
    wait_n(1);
    chk(cke == 4'b1110, "R2 entry rank0 only", int'(cke), 'he);
    chk(pd_kind[2:0] == 3'd1, "R6 kind active", int'(pd_kind[2:0]), 1);

    // R8 minimum low, R9 exit pulse
    req_pending = 4'b1111;
    wait_n(3);
    chk(cke == 4'b1110, "R8 held low", int'(cke), 'he);
    chk(exit_req == '0, "R9 no early exit", int'(exit_req), 0);
    wait_n(1);
    chk(cke == 4'b1111, "R9 exit", int'(cke), 'hf);
    chk(exit_req == 4'b0001, "R9 pulse", int'(exit_req), 1);
    wait_n(1);
    chk(exit_req == '0, "R9 pulse one cycle", int'(exit_req), 0);

    // R3 activity restarts idle count
    req_pending = 4'b1101;
    wait_n(2);
    cmd_issued = 4'b0010;
    wait_n(1);
    cmd_issued = '0;
    wait_n(3);
    chk(cke == 4'b1111, "R3 restart", int'(cke), 'hf);
    wait_n(1);
    chk(cke == 4'b1101, "R3 entry after restart", int'(cke), 'hd);
    req_pending = 4'b1111;
    wait_n(6);

    // R4 threshold zero
    wr_cfg(13'h0100);
    req_pending = '0;
    wait_n(300);
    chk(cke == 4'b1111, "R4 zero threshold", int'(cke), 'hf);

    // R5 off and reserved
    wr_cfg(13'h0002);
    wait_n(10);
    chk(cke == 4'b1111, "R5 mode 0", int'(cke), 'hf);
    wr_cfg(13'h0502);
    wait_n(10);
    chk(cke == 4'b1111, "R5 reserved 5h", int'(cke), 'hf);
    chk(exit_req == '0, "R5 no exit", int'(exit_req), 0);

    // R6 flavour 6h on all ranks
    wr_cfg(13'h0602);
    wait_n(2);
    chk(cke == 4'b0000, "R6 all low", int'(cke), 0);
    for (int r = 0; r < N; r++)
      chk(pd_kind[3*r +: 3] == 3'd4, "R6 kind slow", int'(pd_kind[3*r +: 3]), 4);

    // R10 held write, then R7 global
    wr_cfg(13'h1205);
    wait_n(5);
    chk(pd_kind[2:0] == 3'd4, "R10 write held", int'(pd_kind[2:0]), 4);
    req_pending = 4'b1111;
    wait_n(1);
    chk(cke == 4'b1111, "R9 all exit", int'(cke), 'hf);
    wait_n(1);
    req_pending = 4'b1000;
    wait_n(12);
    chk(cke == 4'b1111, "R7 waits for all ranks", int'(cke), 'hf);
    req_pending = '0;
    wait_n(5);
    chk(cke == 4'b1111, "R7 before threshold", int'(cke), 'hf);
    wait_n(1);
    chk(cke == 4'b0000, "R7 joint entry", int'(cke), 0);
    chk(pd_kind[5:3] == 3'd2, "R10 applied after exit", int'(pd_kind[5:3]), 2);
    wait_n(4);
    req_pending = 4'b0100;
    wait_n(1);
    chk(cke == 4'b1111, "R7 joint wake", int'(cke), 'hf);
    chk(exit_req == 4'b1111, "R7 all pulse", int'(exit_req), 'hf);
    req_pending = '0;

    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      for (int r = 0; r < N; r++) begin
        cmd_issued[r]  = ($urandom_range(0, 15) == 0);
        req_pending[r] = ($urandom_range(0, 11) == 0);
      end
      if ($urandom_range(0, 199) == 0) begin
        automatic logic [3:0] md = 4'($urandom_range(0, 9));
        cfg_word = {1'($urandom_range(0, 1)), md, 8'($urandom_range(0, 7))};
        cfg_wr = 1'b1;
      end else begin
        cfg_wr = 1'b0;
      end
      @(negedge clk);
    end
    cfg_wr = 1'b0;
    cmd_issued = '0;
    req_pending = '0;
    wait_n(2);
    summary();
  end

endmodule